// File: doc/BRIEF.md
# Framed Byte Message Receiver

This block takes in short messages that arrive one byte per clock on a parallel input bus. Besides the data byte, the bus has two sideband bits. One is a start marker that opens a message. The other is an end marker that tags the final byte. The block gathers the bytes into memory words, low byte lane first. It presents each finished word with a word address that counts from zero within the message, so a memory writer further down the chip can store the message into a buffer.

A buffer size limit caps the length of a message. The limit is taken from a configuration input while reset is held, and it stays fixed until the next reset. A message ends either on the end marker or when the byte count reaches the limit. At the end, any partly filled word is flushed and a single-cycle done pulse reports the byte count and the cause of the ending. A start marker that arrives while a message is in progress is ignored. Data seen while no message is open is also ignored.

Top module: `msg_rx`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy`, `wr_valid` and `done` are 0.
- R2: When no message is open, a 1 on `rx_bus[8]` at a rising edge opens a message, and `busy` reads 1 after that edge. The data bits sampled on that edge are discarded. The first byte is `rx_bus[7:0]` sampled on the next rising edge.
- R3: While a message is open, every rising edge takes one byte. Byte k of the message goes to bits [8*(k%4)+7 : 8*(k%4)] of the word whose `wr_addr` is k/4, and word addresses restart at 0 for every message.
- R4: `wr_valid` pulses for one cycle right after the edge that took byte 4w+3 of a message, carrying word w. If the message ends earlier, the pulse comes right after the edge that took the last byte.
- R5: A 1 on `rx_bus[9]` in a byte cycle makes that byte the last one. Right after that edge, `done` pulses with `done_len` equal to the number of bytes taken and `done_by_limit` = 0, and `busy` returns to 0.
- R6: When the byte count reaches the size limit, the message ends with `done_by_limit` = 1 and `done_len` equal to the limit. If the end marker comes on that same byte, `done_by_limit` is 0.
- R7: A final word that is only partly filled is written in the same cycle as `done`, with its unused upper byte lanes set to 0.
- R8: A 1 on `rx_bus[8]` during an open message does not restart it. That cycle's byte is still taken as data.
- R9: The size limit (1 or more) is the value of `cfg_size` while `rst_n` is low. Changes to `cfg_size` after reset have no effect.
- R10: Once a message ends, the block is idle. It ignores data and end markers until a start marker arrives, and it accepts a start marker on the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also loads the size limit |
| cfg_size | input | 12 | Maximum message length in bytes, taken during reset |
| rx_bus | input | 10 | [7:0] data byte, [8] start marker, [9] end marker |
| busy | output | 1 | A message is being received |
| wr_valid | output | 1 | One-cycle pulse: `wr_data` and `wr_addr` hold a word to store |
| wr_addr | output | 10 | Word address within the message buffer |
| wr_data | output | 32 | Packed word, first byte in bits [7:0] |
| done | output | 1 | One-cycle pulse at the end of a message |
| done_len | output | 12 | Number of bytes in the finished message |
| done_by_limit | output | 1 | 1 if the size limit ended the message, 0 if the end marker did |

## Verification
The bench targets messages whose length leaves 1, 2, 3 or 0 bytes in the last word. A design that skipped the flush would lose the tail bytes, and one that left stale lanes would show bytes from an earlier word. It drives the end marker exactly on the limit byte, where a wrong priority flips `done_by_limit`. It also drives the end marker beyond the limit, where a design that ignores the limit runs past the buffer. Stray start markers inside a message would make a careless design restart its count and word address. A start marker placed right after a finished message catches a design that needs a dead cycle. Changing `cfg_size` after reset exposes a design that reads the limit live instead of holding the value from reset.

// File: rtl/msg_rx_pkg.sv
`timescale 1ns/1ps
package msg_rx_pkg;

   typedef enum logic [0:0] {
      RX_IDLE = 1'b0,
      RX_RECV = 1'b1
   } rx_state_e;

   // position of the start and end sideband bits above the data field
   function automatic int start_pos(input int data_w);
      return data_w;
   endfunction

   function automatic int end_pos(input int data_w);
      return data_w + 1;
   endfunction

endpackage

// File: rtl/msg_rx_frame.sv
`timescale 1ns/1ps
module msg_rx_frame
   import msg_rx_pkg::*;
#(
   parameter int LEN_W  = 12,
   parameter int LANE_W = 2,
   localparam int ADDR_W = LEN_W - LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_size,
   input  logic              bus_start,
   input  logic              bus_end,
   output logic              take,
   output logic              last,
   output logic              hit_end,
   output logic [LANE_W-1:0] lane_idx,
   output logic [ADDR_W-1:0] word_idx,
   output logic [LEN_W-1:0]  len_nxt,
   output logic              busy
);

   rx_state_e        state_q;
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] size_q;
   logic [LEN_W-1:0] cnt_inc;
   logic             hit_limit;

   // size limit is held from reset onward
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         size_q <= cfg_size;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= RX_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            RX_IDLE: begin
               if (bus_start) begin
                  state_q <= RX_RECV;
                  cnt_q   <= '0;
               end
            end
            RX_RECV: begin
               cnt_q <= cnt_inc;
               if (last) begin
                  state_q <= RX_IDLE;
               end
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign cnt_inc   = cnt_q + 1'b1;
   assign take      = (state_q == RX_RECV);
   assign hit_limit = (cnt_inc == size_q);
   assign hit_end   = bus_end;
   assign last      = take && (bus_end || hit_limit);
   assign lane_idx  = cnt_q[LANE_W-1:0];
   assign word_idx  = cnt_q[LEN_W-1:LANE_W];
   assign len_nxt   = cnt_inc;
   assign busy      = take;

endmodule

// File: rtl/msg_rx_pack.sv
`timescale 1ns/1ps
module msg_rx_pack #(
   parameter int DATA_W = 8,
   parameter int LANES  = 4,
   parameter int ADDR_W = 10,
   localparam int LANE_W = $clog2(LANES),
   localparam int WORD_W = DATA_W * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              flush,
   input  logic [LANE_W-1:0] lane_idx,
   input  logic [ADDR_W-1:0] word_idx,
   input  logic [DATA_W-1:0] byte_in,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data
);

   logic [WORD_W-1:0] word_d;
   logic              emit;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [DATA_W-1:0] lane_q;
      logic [DATA_W-1:0] lane_d;

      // writing lane 0 opens a fresh word, so every other lane is cleared
      always_comb begin
         if (lane_idx == LANE_W'(g)) begin
            lane_d = byte_in;
         end else if (lane_idx == '0) begin
            lane_d = '0;
         end else begin
            lane_d = lane_q;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lane_q <= '0;
         end else if (take) begin
            lane_q <= lane_d;
         end
      end

      assign word_d[g*DATA_W +: DATA_W] = lane_d;
   end

   assign emit = take && ((lane_idx == LANE_W'(LANES - 1)) || flush);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= emit;
         if (emit) begin
            wr_addr <= word_idx;
            wr_data <= word_d;
         end
      end
   end

endmodule

// File: rtl/msg_rx_stat.sv
`timescale 1ns/1ps
module msg_rx_stat #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             last,
   input  logic             hit_end,
   input  logic [LEN_W-1:0] len_nxt,
   output logic             done,
   output logic [LEN_W-1:0] done_len,
   output logic             done_by_limit
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done          <= 1'b0;
         done_len      <= '0;
         done_by_limit <= 1'b0;
      end else begin
         done <= last;
         if (last) begin
            done_len      <= len_nxt;
            // the end marker takes priority over the limit
            done_by_limit <= !hit_end;
         end
      end
   end

endmodule

// File: rtl/msg_rx.sv
`timescale 1ns/1ps
module msg_rx
   import msg_rx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LANES  = 4,
   parameter int LEN_W  = 12,
   localparam int LANE_W = $clog2(LANES),
   localparam int ADDR_W = LEN_W - LANE_W,
   localparam int WORD_W = DATA_W * LANES,
   localparam int BUS_W  = DATA_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LEN_W-1:0]  cfg_size,
   input  logic [BUS_W-1:0]  rx_bus,
   output logic              busy,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic              done,
   output logic [LEN_W-1:0]  done_len,
   output logic              done_by_limit
);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("msg_rx: LANES must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("msg_rx: DATA_W must be positive");
   end
   if (LEN_W <= LANE_W) begin : g_bad_len
      $error("msg_rx: LEN_W must exceed the lane index width");
   end

   logic              take;
   logic              last;
   logic              hit_end;
   logic [LANE_W-1:0] lane_idx;
   logic [ADDR_W-1:0] word_idx;
   logic [LEN_W-1:0]  len_nxt;

   msg_rx_frame #(
      .LEN_W  (LEN_W),
      .LANE_W (LANE_W)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_size  (cfg_size),
      .bus_start (rx_bus[start_pos(DATA_W)]),
      .bus_end   (rx_bus[end_pos(DATA_W)]),
      .take      (take),
      .last      (last),
      .hit_end   (hit_end),
      .lane_idx  (lane_idx),
      .word_idx  (word_idx),
      .len_nxt   (len_nxt),
      .busy      (busy)
   );

   msg_rx_pack #(
      .DATA_W (DATA_W),
      .LANES  (LANES),
      .ADDR_W (ADDR_W)
   ) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .flush    (last),
      .lane_idx (lane_idx),
      .word_idx (word_idx),
      .byte_in  (rx_bus[DATA_W-1:0]),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   msg_rx_stat #(
      .LEN_W (LEN_W)
   ) u_stat (
      .clk           (clk),
      .rst_n         (rst_n),
      .last          (last),
      .hit_end       (hit_end),
      .len_nxt       (len_nxt),
      .done          (done),
      .done_len      (done_len),
      .done_by_limit (done_by_limit)
   );

endmodule

// File: rtl/msg_rx_chk.sv
`timescale 1ns/1ps
module msg_rx_chk #(
   parameter int DATA_W = 8,
   parameter int LANES  = 4,
   parameter int LEN_W  = 12,
   localparam int LANE_W = $clog2(LANES),
   localparam int WORD_W = DATA_W * LANES
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_start,
   input logic              busy,
   input logic              wr_valid,
   input logic [WORD_W-1:0] wr_data,
   input logic              done,
   input logic [LEN_W-1:0]  done_len
);

   function automatic logic [WORD_W-1:0] pad_mask(input logic [LEN_W-1:0] len);
      logic [LANE_W-1:0] rem;
      logic [WORD_W-1:0] m;
      rem = len[LANE_W-1:0];
      m   = '0;
      for (int l = 0; l < LANES; l++) begin
         if (rem != '0 && l >= int'(rem)) begin
            m[l*DATA_W +: DATA_W] = '1;
         end
      end
      return m;
   endfunction

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!busy && !wr_valid && !done));

   assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rx_start) |=> busy);

   assert_word_in_msg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> $past(busy));

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_len != '0));

   assert_flush_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> wr_valid);

   assert_pad_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((wr_data & pad_mask(done_len)) == '0));

   assert_single_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind msg_rx msg_rx_chk #(
   .DATA_W (DATA_W),
   .LANES  (LANES),
   .LEN_W  (LEN_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_start (rx_bus[DATA_W]),
   .busy     (busy),
   .wr_valid (wr_valid),
   .wr_data  (wr_data),
   .done     (done),
   .done_len (done_len)
);

// File: tb/msg_rx_tb.sv
`timescale 1ns/1ps
module msg_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] cfg_size = 12'd16;
   logic [9:0]  rx_bus = '0;
   logic        busy, wr_valid, done, done_by_limit;
   logic [9:0]  wr_addr;
   logic [31:0] wr_data;
   logic [11:0] done_len;

   msg_rx u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .rx_bus(rx_bus),
      .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .done(done), .done_len(done_len), .done_by_limit(done_by_limit)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;
   int pc = 0;

   int          lg_n = 0;
   int          lg_stamp [4096];
   bit          lg_done  [4096];
   logic [31:0] lg_data  [4096];
   int          lg_addr  [4096];
   int          lg_len   [4096];
   bit          lg_lim   [4096];

   logic [7:0] msgbuf [2][64];
   int cur_size = 16;

   // event monitor: records outputs 1 ns after each rising edge
   always @(posedge clk) begin
      pc = pc + 1;
      #1;
      if (wr_valid && lg_n < 4096) begin
         lg_stamp[lg_n] = pc; lg_done[lg_n] = 1'b0;
         lg_data[lg_n] = wr_data; lg_addr[lg_n] = int'(wr_addr);
         lg_n = lg_n + 1;
      end
      if (done && lg_n < 4096) begin
         lg_stamp[lg_n] = pc; lg_done[lg_n] = 1'b1;
         lg_len[lg_n] = int'(done_len); lg_lim[lg_n] = done_by_limit;
         lg_n = lg_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input int size);
      @(negedge clk);
      rst_n = 1'b0; cfg_size = 12'(size); rx_bus = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cur_size = size;
      chk(!busy && !wr_valid && !done, "R1", "outputs quiet after reset",
          longint'({busy, wr_valid, done}), 0);
   endtask

   task automatic fill(input int slot, input int n);
      for (int i = 0; i < n; i++) msgbuf[slot][i] = 8'($urandom);
   endtask

   task automatic send_msg(input int slot, input int n, input int eom_at,
                           input int stray_at, output int c0);
      @(negedge clk);
      c0 = pc;
      rx_bus = {1'b0, 1'b1, 8'($urandom)};
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (i == 0) chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
         rx_bus = {(i == eom_at), (i == stray_at), msgbuf[slot][i]};
      end
   endtask

   // random data with end markers but no start marker; nothing may come out
   task automatic idle_noise(input int k);
      int s0;
      int ev;
      @(negedge clk);
      s0 = pc;
      rx_bus = {1'($urandom), 1'b0, 8'($urandom)};
      for (int j = 1; j < k; j++) begin
         @(negedge clk);
         rx_bus = {1'($urandom), 1'b0, 8'($urandom)};
      end
      @(negedge clk);
      rx_bus = '0;
      ev = 0;
      for (int e = 0; e < lg_n; e++)
         if (lg_stamp[e] >= s0 + 1 && lg_stamp[e] <= s0 + k) ev = ev + 1;
      chk(ev == 0, "R10", "no output while idle", longint'(ev), 0);
      chk(!busy, "R10", "idle stays idle without start", longint'(busy), 0);
   endtask

   function automatic int exp_len(input int eom_at, input int size);
      if (eom_at >= 0 && eom_at < size) return eom_at + 1;
      return size;
   endfunction

   function automatic logic [31:0] exp_word(input int slot, input int w, input int len);
      logic [31:0] v = '0;
      for (int l = 0; l < 4; l++)
         if (4 * w + l < len) v[8*l +: 8] = msgbuf[slot][4*w+l];
      return v;
   endfunction

   task automatic check_msg(input int slot, input int c0, input int eom_at,
                            input int size);
      int len, nw, w, nd, last_idx;
      bit lim;
      len = exp_len(eom_at, size);
      lim = !(eom_at >= 0 && eom_at < size);
      nw = (len + 3) / 4;
      w = 0; nd = 0;
      for (int e = 0; e < lg_n; e++) begin
         if (lg_stamp[e] >= c0 + 2 && lg_stamp[e] <= c0 + 1 + len) begin
            if (lg_done[e]) begin
               nd = nd + 1;
               chk(lg_stamp[e] == c0 + 1 + len, "R5", "done timing",
                   longint'(lg_stamp[e] - c0), longint'(1 + len));
               chk(lg_len[e] == len, "R5", "done_len",
                   longint'(lg_len[e]), longint'(len));
               chk(lg_lim[e] == lim, "R6", "done_by_limit",
                   longint'(lg_lim[e]), longint'(lim));
            end else begin
               last_idx = (4 * w + 3 < len - 1) ? 4 * w + 3 : len - 1;
               chk(lg_data[e] == exp_word(slot, w, len),
                   (w == nw - 1 && (len % 4) != 0) ? "R7" : "R3", "word data",
                   longint'(lg_data[e]), longint'(exp_word(slot, w, len)));
               chk(lg_addr[e] == w, "R3", "word address",
                   longint'(lg_addr[e]), longint'(w));
               chk(lg_stamp[e] == c0 + 2 + last_idx, "R4", "word timing",
                   longint'(lg_stamp[e] - c0), longint'(2 + last_idx));
               w = w + 1;
            end
         end
      end
      chk(w == nw, "R4", "word count", longint'(w), longint'(nw));
      chk(nd == 1, "R5", "done count", longint'(nd), 1);
   endtask

   task automatic run_one(input int n, input int eom_at, input int stray_at);
      int c0;
      fill(0, n);
      send_msg(0, n, eom_at, stray_at, c0);
      idle_noise(4);
      check_msg(0, c0, eom_at, cur_size);
   endtask

   initial begin
      int ca, cb, sd, mode, eom, n, len, stray;
      sd = int'($urandom(32'd20240611));
      do_reset(16);
      // R5 R7: ends on marker with a three-byte tail
      run_one(7, 6, -1);
      // R3: two full words
      run_one(8, 7, -1);
      // R6: limit ends the message
      run_one(20, -1, -1);
      // R6: end marker on the limit byte
      run_one(16, 15, -1);
      // R6: end marker beyond the limit
      run_one(18, 17, -1);
      // R8: stray start markers inside the message
      run_one(11, 10, 3);
      run_one(6, 5, 0);
      // R7: single byte message
      run_one(1, 0, -1);
      // R10: back-to-back messages
      fill(0, 5); fill(1, 9);
      send_msg(0, 5, 4, -1, ca);
      send_msg(1, 9, 8, -1, cb);
      idle_noise(3);
      check_msg(0, ca, 4, cur_size);
      check_msg(1, cb, 8, cur_size);
      // R9: limit fixed at reset, later cfg changes ignored
      do_reset(5);
      cfg_size = 12'd30;
      run_one(12, -1, -1);
      // random messages with periodic resets
      for (int r = 0; r < 40; r++) begin
         if (r % 10 == 0) do_reset(1 + int'($urandom % 40));
         mode = int'($urandom % 3);
         if (mode == 0) begin
            eom = int'($urandom % cur_size); n = eom + 1 + int'($urandom % 4);
         end else if (mode == 1) begin
            eom = -1; n = cur_size + int'($urandom % 4);
         end else begin
            eom = cur_size + int'($urandom % 3); n = eom + 1;
         end
         len = exp_len(eom, cur_size);
         stray = ($urandom % 2 == 1) ? int'($urandom % len) : -1;
         run_one(n, eom, stray);
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         n_fail = n_fail + 1;
         $display("FAIL R10 watchdog expired act=0 exp=1");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule